// File: doc/BRIEF.md
# Logical Immediate Bitmask Encoder

This block decides whether a 32-bit or 64-bit constant can be written as the immediate operand of a 64-bit processor's bitwise logic instructions (AND, OR, XOR with an immediate). Such an immediate is a power-of-two-sized element that repeats across the operand width. Inside the element sits a single circular run of ones. When the constant has that shape, the block returns the three encoding fields: the wide-element flag N, the rotation field immr and the size/length field imms. It also returns the fields packed into one 13-bit word.

An instruction builder places a constant on `in_value`, selects the operand width with `in_wide` and pulses `in_valid`. The block does all of its search in combinational logic. The verdict and fields appear in registers on the next clock edge. Each presented constant yields one result, and a new constant may be presented on every cycle.

Top module: `lim_encoder`

## Requirements
- R1: A result registers on the rising edge that samples `in_valid` high. `out_valid` is high for exactly that one cycle and low after any edge that samples `in_valid` low.
- R2: With `in_wide` = 0, bits 63:32 of `in_value` have no effect on any output.
- R3: A value that is all zeros or all ones across the selected width is rejected with `out_ok` = 0.
- R4: The element size e is the smallest of 2, 4, 8, 16, 32, 64 that is not larger than the selected width (32 or 64) such that every e-bit chunk of the value equals its lowest chunk.
- R5: A value is accepted only if some right rotation r (0 ≤ r ≤ e-1) of the element leaves k low ones and zeros above, with 1 ≤ k ≤ e-1. A non-contiguous element gives `out_ok` = 0.
- R6: `out_immr` = r. `out_imms` = a size prefix ORed with (k-1) kept to the low bits. The patterns are: e=2 gives 11110s, e=4 gives 1110ss, e=8 gives 110sss, e=16 gives 10ssss, e=32 gives 0sssss and e=64 gives ssssss.
- R7: `out_n` is 1 only for e = 64, so it is always 0 in 32-bit mode.
- R8: `out_packed` holds N at bit 12, immr at bits 11:6 and imms at bits 5:0.
- R9: When several rotations qualify, the smallest r is reported.
- R10: Whenever `out_ok` is 0, `out_n`, `out_immr`, `out_imms` and `out_packed` are all zero, including idle cycles.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_ok` and every output field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Constant on `in_value` is to be encoded |
| in_value | input | 64 | Constant to test |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| out_valid | output | 1 | One-cycle pulse: result fields are current |
| out_ok | output | 1 | Constant is encodable |
| out_n | output | 1 | Wide-element flag N |
| out_immr | output | 6 | Rotation field |
| out_imms | output | 6 | Element size prefix and run length field |
| out_packed | output | 13 | {N, immr, imms} |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`. There is no other pipeline stage between the input and the output registers. The bench changes inputs on the falling edge and lets one rising edge pass. It reads all outputs on the next falling edge and checks `out_valid`, `out_ok`, the three fields and the packed word together at that point. After some constants it holds `in_valid` low for one cycle and checks, one falling edge later, that the valid pulse has ended and the fields have returned to zero.

// File: rtl/lim_pkg.sv
package lim_pkg;
    localparam int VAL_W     = 64;
    localparam int FLD_W     = 6;
    localparam int PACK_W    = 2 * FLD_W + 1;
    localparam int NUM_SIZES = 6;
    localparam int CNT_W     = FLD_W + 1;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic              n;
        logic [FLD_W-1:0]  immr;
        logic [FLD_W-1:0]  imms;
        logic [PACK_W-1:0] packed_word;
    } lim_result_t;
endpackage

// File: rtl/lim_period_detect.sv
module lim_period_detect
    import lim_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NSIZES = NUM_SIZES
) (
    input  logic [W-1:0]      value,
    input  logic              wide,
    output logic [NSIZES-1:0] size_oh,
    output logic [W-1:0]      elem
);
    localparam int HALF = W / 2;

    logic [NSIZES-1:0] rep_wide;
    logic [NSIZES-1:0] rep_narrow;
    logic [NSIZES-1:0] rep_sel;
    logic [W-1:0]      masked [NSIZES];

    for (genvar j = 0; j < NSIZES; j++) begin : g_size
        localparam int E = 2 << j;
        localparam logic [W-1:0] EMASK = {W{1'b1}} >> (W - E);

        if (E < W) begin : g_w_rot
            assign rep_wide[j] = (value == {value[W-E-1:0], value[W-1:W-E]});
        end else begin : g_w_full
            assign rep_wide[j] = 1'b1;
        end

        if (E < HALF) begin : g_n_rot
            assign rep_narrow[j] =
                (value[HALF-1:0] == {value[HALF-E-1:0], value[HALF-1:HALF-E]});
        end else if (E == HALF) begin : g_n_full
            assign rep_narrow[j] = 1'b1;
        end else begin : g_n_none
            assign rep_narrow[j] = 1'b0;
        end

        assign masked[j] = value & EMASK;
    end

    always_comb begin
        rep_sel = wide ? rep_wide : rep_narrow;
        size_oh = rep_sel & (~rep_sel + NSIZES'(1));
        elem    = '0;
        for (int j = 0; j < NSIZES; j++) begin
            if (size_oh[j]) begin
                elem = masked[j];
            end
        end
    end

    always_comb begin
        if (!$isunknown(value) && !$isunknown(wide)) begin
            // R4
            size_onehot_chk: assert ($onehot(size_oh));
        end
    end
endmodule

// File: rtl/lim_run_finder.sv
module lim_run_finder
    import lim_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NSIZES = NUM_SIZES,
    parameter int FW     = FLD_W,
    parameter int CW     = CNT_W
) (
    input  logic [W-1:0]      elem,
    input  logic [NSIZES-1:0] size_oh,
    output logic              found,
    output logic [FW-1:0]     rot,
    output logic [CW-1:0]     ones_cnt
);
    logic [NSIZES-1:0] hit;
    logic [FW-1:0]     rot_arr [NSIZES];
    logic [CW-1:0]     cnt_arr [NSIZES];

    for (genvar j = 0; j < NSIZES; j++) begin : g_size
        localparam int E = 2 << j;
        logic [E-1:0]  seg;
        logic [E-1:0]  starts;
        logic [CW-1:0] n_starts;
        logic [CW-1:0] pop;
        logic [FW-1:0] pos;

        always_comb begin
            seg      = elem[E-1:0];
            starts   = seg & ~{seg[E-2:0], seg[E-1]};
            n_starts = '0;
            pop      = '0;
            pos      = '0;
            for (int i = 0; i < E; i++) begin
                if (starts[i]) begin
                    n_starts = n_starts + CW'(1);
                    pos      = FW'(i);
                end
                pop = pop + CW'(seg[i]);
            end
        end

        assign hit[j]     = (n_starts == CW'(1));
        assign rot_arr[j] = pos;
        assign cnt_arr[j] = pop;

        always_comb begin
            if (!$isunknown(elem) && hit[j]) begin
                // R5
                run_len_range_chk: assert (pop >= CW'(1) && pop < CW'(E));
            end
        end
    end

    always_comb begin
        found    = 1'b0;
        rot      = '0;
        ones_cnt = '0;
        for (int j = 0; j < NSIZES; j++) begin
            if (size_oh[j]) begin
                found    = hit[j];
                rot      = rot_arr[j];
                ones_cnt = cnt_arr[j];
            end
        end
    end
endmodule

// File: rtl/lim_field_pack.sv
module lim_field_pack
    import lim_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NSIZES = NUM_SIZES,
    parameter int FW     = FLD_W,
    parameter int CW     = CNT_W,
    parameter int PW     = PACK_W
) (
    input  logic [NSIZES-1:0] size_oh,
    input  logic              accept,
    input  logic [FW-1:0]     rot,
    input  logic [CW-1:0]     ones_cnt,
    output logic              n_bit,
    output logic [FW-1:0]     immr,
    output logic [FW-1:0]     imms,
    output logic [PW-1:0]     packed_word
);
    logic [FW-1:0] len_m1;

    always_comb begin
        len_m1 = FW'(ones_cnt - CW'(1));
        n_bit  = 1'b0;
        immr   = '0;
        imms   = '0;
        if (accept) begin
            immr = rot;
            for (int j = 0; j < NSIZES; j++) begin
                if (size_oh[j]) begin
                    imms  = FW'(~((2 << (j + 1)) - 1)) | (len_m1 & FW'((2 << j) - 1));
                    n_bit = ((2 << j) == W);
                end
            end
        end
        packed_word = {n_bit, immr, imms};
    end

    always_comb begin
        if (!$isunknown(size_oh) && !$isunknown(accept)) begin
            // R7
            wide_flag_size_chk: assert (!n_bit || size_oh[NSIZES-1]);
        end
    end
endmodule

// File: rtl/lim_encoder.sv
module lim_encoder
    import lim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       in_value,
    input  logic              in_wide,
    output logic              out_valid,
    output logic              out_ok,
    output logic              out_n,
    output logic [5:0]        out_immr,
    output logic [5:0]        out_imms,
    output logic [12:0]       out_packed
);
    localparam int HALF = VAL_W / 2;

    logic [VAL_W-1:0]     value_w;
    logic [NUM_SIZES-1:0] size_oh;
    logic [VAL_W-1:0]     elem;
    logic                 run_found;
    logic [FLD_W-1:0]     rot;
    logic [CNT_W-1:0]     ones_cnt;
    logic                 all_zero;
    logic                 all_ones;
    logic                 accept;
    logic                 f_n;
    logic [FLD_W-1:0]     f_immr;
    logic [FLD_W-1:0]     f_imms;
    logic [PACK_W-1:0]    f_packed;
    lim_result_t          res_d;
    lim_result_t          res_q;

    assign value_w  = in_wide ? in_value : {{HALF{1'b0}}, in_value[HALF-1:0]};
    assign all_zero = (value_w == '0);
    assign all_ones = in_wide ? (&in_value) : (&in_value[HALF-1:0]);
    assign accept   = run_found & ~all_zero & ~all_ones;

    lim_period_detect #(.W(VAL_W), .NSIZES(NUM_SIZES)) i_period (
        .value   (value_w),
        .wide    (in_wide),
        .size_oh (size_oh),
        .elem    (elem)
    );

    lim_run_finder #(.W(VAL_W), .NSIZES(NUM_SIZES), .FW(FLD_W), .CW(CNT_W)) i_run (
        .elem     (elem),
        .size_oh  (size_oh),
        .found    (run_found),
        .rot      (rot),
        .ones_cnt (ones_cnt)
    );

    lim_field_pack #(.W(VAL_W), .NSIZES(NUM_SIZES), .FW(FLD_W), .CW(CNT_W), .PW(PACK_W)) i_pack (
        .size_oh     (size_oh),
        .accept      (accept),
        .rot         (rot),
        .ones_cnt    (ones_cnt),
        .n_bit       (f_n),
        .immr        (f_immr),
        .imms        (f_imms),
        .packed_word (f_packed)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        if (in_valid && accept) begin
            res_d.ok          = 1'b1;
            res_d.n           = f_n;
            res_d.immr        = f_immr;
            res_d.imms        = f_imms;
            res_d.packed_word = f_packed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_ok     = res_q.ok;
    assign out_n      = res_q.n;
    assign out_immr   = res_q.immr;
    assign out_imms   = res_q.imms;
    assign out_packed = res_q.packed_word;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    zero_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_value == 64'd0) |=> !out_ok);
    // R7
    narrow_n_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide) |=> !out_n);
    // R10
    reject_zero_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !out_ok |-> (out_packed == '0 && out_immr == '0 && out_imms == '0 && !out_n));
    // R8
    packed_layout_chk: assert property (@(posedge clk) disable iff (rst)
        out_packed == {out_n, out_immr, out_imms});
endmodule

// File: tb/test_lim_encoder.sv
module test_lim_encoder;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic        in_wide = 1'b0;
    logic        out_valid, out_ok, out_n;
    logic [5:0]  out_immr, out_imms;
    logic [12:0] out_packed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lim_encoder i_lim_encoder (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_value   (in_value),
        .in_wide    (in_wide),
        .out_valid  (out_valid),
        .out_ok     (out_ok),
        .out_n      (out_n),
        .out_immr   (out_immr),
        .out_imms   (out_imms),
        .out_packed (out_packed)
    );

    // Returns {ok, n, immr, imms}; search follows R3..R9 directly.
    function automatic logic [13:0] model(input logic [63:0] val, input logic wide);
        int w = wide ? 64 : 32;
        logic [63:0] v = wide ? val : {32'd0, val[31:0]};
        logic [63:0] full = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
        int e = 2;
        logic [63:0] el;
        logic [63:0] rr;
        bit rep;
        int k;
        logic [5:0] imms;
        if (v == 0 || v == full) return '0;
        while (e < w) begin
            rep = 1;
            for (int i = 0; i < w; i++) if (v[i] != v[i % e]) rep = 0;
            if (rep) break;
            e = e * 2;
        end
        el = '0;
        for (int i = 0; i < e; i++) el[i] = v[i];
        for (int r = 0; r < e; r++) begin
            rr = '0;
            for (int i = 0; i < e; i++) rr[i] = el[(i + r) % e];
            k = 0;
            while (k < e && rr[k]) k++;
            if (k >= 1 && k < e && (rr >> k) == 0) begin
                case (e)
                    2:  imms = 6'b111100 | 6'(k - 1);
                    4:  imms = 6'b111000 | 6'(k - 1);
                    8:  imms = 6'b110000 | 6'(k - 1);
                    16: imms = 6'b100000 | 6'(k - 1);
                    default: imms = 6'(k - 1);
                endcase
                return {1'b1, (e == 64), 6'(r), imms};
            end
        end
        return '0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s value=%h wide=%0d actual=%h expected=%h",
                     req, in_value, in_wide, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] val, input logic wide, input string req, input bit idle);
        logic [13:0] e;
        e = model(val, wide);
        in_valid = 1'b1;
        in_value = val;
        in_wide  = wide;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({"R1 ", req}, 64'(out_valid), 64'd1);
        check({req, " ok"}, 64'(out_ok), 64'(e[13]));
        check({req, " fields"}, {51'd0, out_n, out_immr, out_imms}, {51'd0, e[12:0]});
        check({"R8 ", req}, 64'(out_packed), 64'(e[12:0]));
        if (idle) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 idle valid", 64'(out_valid), 64'd0);
            check("R10 idle fields", {50'd0, out_ok, out_packed}, 64'd0);
        end
    endtask

    function automatic logic [63:0] build(input int e, input int k, input int r);
        logic [63:0] pat = '0;
        logic [63:0] v;
        for (int i = 0; i < k; i++) pat[(i + r) % e] = 1'b1;
        for (int i = 0; i < 64; i++) v[i] = pat[i % e];
        return v;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1357));
        @(negedge clk);
        @(negedge clk);
        check("R11 reset valid", 64'(out_valid), 64'd0);
        check("R11 reset fields", {50'd0, out_ok, out_packed}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3 edges
        apply(64'd0, 1'b1, "R3 zero64", 1);
        apply(64'd0, 1'b0, "R3 zero32", 0);
        apply('1, 1'b1, "R3 ones64", 0);
        apply(64'hDEAD_BEEF_FFFF_FFFF, 1'b0, "R3 R2 ones32", 1);
        // R4 R6 small elements
        apply(64'h5555_5555_5555_5555, 1'b1, "R4 R6 e2", 0);
        apply(64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R6 e2 rot", 0);
        apply(64'h00FF_00FF_00FF_00FF, 1'b1, "R4 R6 e16", 0);
        apply(64'h7777_7777_7777_7777, 1'b1, "R6 e4", 0);
        // R7 wide element
        apply(64'h0000_0000_0000_0001, 1'b1, "R7 e64", 0);
        apply(64'h8000_0000_0000_0000, 1'b1, "R7 R9 r63", 0);
        apply(64'hFFFF_FFFF_FFFF_FFFE, 1'b1, "R7 k63", 0);
        apply(64'h8000_0000_0000_0001, 1'b1, "R9 wrap run", 0);
        // R2 upper bits ignored in 32-bit mode
        apply(64'h1234_5678_0000_000F, 1'b0, "R2 e32", 0);
        apply(64'hFFFF_FFFF_0000_000F, 1'b0, "R2 e32 b", 0);
        apply(64'h0000_0000_0000_000F, 1'b1, "R4 same value wide", 0);
        // R5 R10 non-contiguous
        apply(64'h0000_0000_0000_0005, 1'b1, "R5 R10 gap", 1);
        apply(64'h0000_0005_0000_0005, 1'b1, "R5 gap e32", 0);

        for (int t = 0; t < 200; t++) begin
            int wide = $urandom_range(0, 1);
            int j = $urandom_range(0, wide ? 5 : 4);
            int e = 2 << j;
            int k = $urandom_range(1, e - 1);
            int r = $urandom_range(0, e - 1);
            logic [63:0] v = build(e, k, r);
            if (!wide) v[63:32] = $urandom;
            apply(v, wide[0], "R4 R5 R6 R9 built", (t % 7) == 0);
        end
        for (int t = 0; t < 150; t++) begin
            logic [63:0] v = {$urandom, $urandom};
            apply(v, 1'($urandom_range(0, 1)), "R5 R10 random", (t % 11) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule